// File: doc/BRIEF.md
# Return Stack with Carry Save

This block holds return addresses for a small 4-bit processor. A subroutine call or an accepted interrupt pushes the 11-bit address that follows the current instruction, together with the carry flag of that moment. Calls and interrupts share the same four entries. When a fifth push arrives on a full stack, the oldest entry is quietly lost and nothing stalls.

Two kinds of return pop the stack. The interrupt return hands back both the address and the saved carry, and asks the core to reload its carry flag. The value return hands back only the address and leaves the carry flag alone. In the same cycle it presents two 4-bit immediates for the table branch register and the accumulator, each with a write strobe.

All results are registered and appear in the cycle after the request strobe. A depth count from 0 to 4 is visible at all times. If a push and a pop are requested in the same cycle, the block raises an error flag and carries out neither.

Top module: `ret_stack`

## Requirements
- R1: After reset, depth_o is 0 and ret_valid_o, cy_load_o, ld_imm_o, err_o, ret_pc_o, ret_cy_o, tbr_o and acc_o are all 0.
- R2: A push strobe alone stores (push_pc_i + 1) modulo 2^11 together with push_cy_i, and depth_o rises by one on the next cycle while it is below 4.
- R3: Pops return the stored entries in last-in, first-out order.
- R4: A push on a full stack (depth 4) drops the oldest entry and keeps depth_o at 4. The four pops that follow return the four newest entries.
- R5: A carry-restore pop (pop_cy_i) gives, on the next cycle, ret_valid_o=1 and cy_load_o=1, with ret_pc_o and ret_cy_o equal to the popped entry, and lowers depth_o by one.
- R6: A value pop (pop_keep_i) gives, on the next cycle, ret_valid_o=1, the popped address on ret_pc_o, cy_load_o=0 and ld_imm_o=1, with tbr_o = imm_tbr_i and acc_o = imm_acc_i.
- R7: A pop on an empty stack returns ret_pc_o=0 and ret_cy_o=0 with ret_valid_o=1, and depth_o stays 0.
- R8: When more than one of push_i, pop_cy_i and pop_keep_i is high in a cycle, err_o is 1 on the next cycle, ret_valid_o stays 0, and neither depth_o nor the stored entries change.
- R9: depth_o never exceeds 4 and never wraps below 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| push_pc_i | input | 11 | Address of the current instruction, bits 10..0 |
| push_cy_i | input | 1 | Carry flag to save with the entry |
| pop_cy_i | input | 1 | Pop strobe that restores the carry |
| pop_keep_i | input | 1 | Pop strobe that keeps the carry and loads the immediates |
| imm_tbr_i | input | 4 | Immediate for the table branch register |
| imm_acc_i | input | 4 | Immediate for the accumulator |
| ret_valid_o | output | 1 | A pop completed; ret_pc_o is valid |
| ret_pc_o | output | 11 | Popped return address |
| ret_cy_o | output | 1 | Popped carry value |
| cy_load_o | output | 1 | Core should load ret_cy_o into its carry flag |
| ld_imm_o | output | 1 | Core should load tbr_o and acc_o |
| tbr_o | output | 4 | Table branch register value |
| acc_o | output | 4 | Accumulator value |
| depth_o | output | 3 | Number of stored entries, 0 to 4 |
| err_o | output | 1 | Push and pop were requested together last cycle |

## Verification
The bench pushes the all-ones address to check that PC+1 wraps to 0. A design that saved the raw address, or added one at the wrong width, would return 0x7FF or a 12-bit value. It pushes five entries and then pops until the stack is empty. A design that blocked the fifth push, or dropped the newest entry instead of the oldest, would return the wrong sequence, and a design that kept stale data would return a nonzero address from the empty pop. It also sends a push and a pop in the same cycle, then checks that the earlier entry still comes back intact. Finally it checks that the value pop raises no carry-load strobe.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int RS_ADDR_W = 11;
  localparam int RS_NIB_W  = 4;

  typedef struct packed {
    logic                 cy;
    logic [RS_ADDR_W-1:0] pc;
  } rs_entry_t;

  // return address saved by a call: the next instruction, wrapping in 11 bits
  function automatic logic [RS_ADDR_W-1:0] next_ret_addr(input logic [RS_ADDR_W-1:0] pc);
    return pc + RS_ADDR_W'(1);
  endfunction

  // more than one request in a cycle is illegal
  function automatic logic req_clash(input logic a, input logic b, input logic c);
    return ($countones({a, b, c}) > 1);
  endfunction
endpackage

// File: rtl/rs_decode.sv
module rs_decode (
  input  logic push_i,
  input  logic pop_cy_i,
  input  logic pop_keep_i,
  output logic do_push_o,
  output logic do_pop_o,
  output logic pop_cy_ok_o,
  output logic pop_keep_ok_o,
  output logic clash_o
);
  import ret_stack_pkg::*;

  always_comb begin
    clash_o       = req_clash(push_i, pop_cy_i, pop_keep_i);
    do_push_o     = push_i     & ~clash_o;
    pop_cy_ok_o   = pop_cy_i   & ~clash_o;
    pop_keep_ok_o = pop_keep_i & ~clash_o;
    do_pop_o      = pop_cy_ok_o | pop_keep_ok_o;
  end
endmodule

// File: rtl/rs_storage.sv
module rs_storage #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     do_push_i,
  input  logic                     do_pop_i,
  input  ret_stack_pkg::rs_entry_t new_i,
  output ret_stack_pkg::rs_entry_t top_o
);
  import ret_stack_pkg::*;

  rs_entry_t slot     [DEPTH];
  rs_entry_t from_up  [DEPTH];  // value a slot takes on push
  rs_entry_t from_dn  [DEPTH];  // value a slot takes on pop

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_first
      assign from_up[i] = new_i;
    end else begin : g_inner_up
      assign from_up[i] = slot[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign from_dn[i] = '0;
    end else begin : g_inner_dn
      assign from_dn[i] = slot[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         slot[i] <= '0;
      else if (do_push_i) slot[i] <= from_up[i];
      else if (do_pop_i)  slot[i] <= from_dn[i];
    end
  end

  assign top_o = slot[0];
endmodule

// File: rtl/rs_depth.sv
module rs_depth #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_push_i,
  input  logic          do_pop_i,
  output logic [CW-1:0] depth_o,
  output logic          empty_o
);
  logic full;

  assign full    = (depth_o == CW'(DEPTH));
  assign empty_o = (depth_o == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    depth_o <= '0;
    else if (do_push_i && !full)   depth_o <= depth_o + CW'(1);
    else if (do_pop_i && !empty_o) depth_o <= depth_o - CW'(1);
  end
endmodule

// File: rtl/rs_return.sv
module rs_return (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   pop_cy_i,
  input  logic                                   pop_keep_i,
  input  logic                                   empty_i,
  input  logic                                   clash_i,
  input  ret_stack_pkg::rs_entry_t               top_i,
  input  logic [ret_stack_pkg::RS_NIB_W-1:0]     imm_tbr_i,
  input  logic [ret_stack_pkg::RS_NIB_W-1:0]     imm_acc_i,
  output logic                                   ret_valid_o,
  output logic [ret_stack_pkg::RS_ADDR_W-1:0]    ret_pc_o,
  output logic                                   ret_cy_o,
  output logic                                   cy_load_o,
  output logic                                   ld_imm_o,
  output logic [ret_stack_pkg::RS_NIB_W-1:0]     tbr_o,
  output logic [ret_stack_pkg::RS_NIB_W-1:0]     acc_o,
  output logic                                   err_o
);
  import ret_stack_pkg::*;

  rs_entry_t popped;
  logic      any_pop;

  assign any_pop = pop_cy_i | pop_keep_i;
  assign popped  = empty_i ? '0 : top_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_valid_o <= 1'b0;
      ret_pc_o    <= '0;
      ret_cy_o    <= 1'b0;
      cy_load_o   <= 1'b0;
      ld_imm_o    <= 1'b0;
      tbr_o       <= '0;
      acc_o       <= '0;
      err_o       <= 1'b0;
    end else begin
      ret_valid_o <= any_pop;
      cy_load_o   <= pop_cy_i;
      ld_imm_o    <= pop_keep_i;
      err_o       <= clash_i;
      if (any_pop) begin
        ret_pc_o <= popped.pc;
        ret_cy_o <= popped.cy;
      end
      if (pop_keep_i) begin
        tbr_o <= imm_tbr_i;
        acc_o <= imm_acc_i;
      end
    end
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH+1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                push_i,
  input  logic [ret_stack_pkg::RS_ADDR_W-1:0] push_pc_i,
  input  logic                                push_cy_i,
  input  logic                                pop_cy_i,
  input  logic                                pop_keep_i,
  input  logic [ret_stack_pkg::RS_NIB_W-1:0]  imm_tbr_i,
  input  logic [ret_stack_pkg::RS_NIB_W-1:0]  imm_acc_i,
  output logic                                ret_valid_o,
  output logic [ret_stack_pkg::RS_ADDR_W-1:0] ret_pc_o,
  output logic                                ret_cy_o,
  output logic                                cy_load_o,
  output logic                                ld_imm_o,
  output logic [ret_stack_pkg::RS_NIB_W-1:0]  tbr_o,
  output logic [ret_stack_pkg::RS_NIB_W-1:0]  acc_o,
  output logic [CW-1:0]                       depth_o,
  output logic                                err_o
);
  import ret_stack_pkg::*;

  // named internal events
  logic      ev_push, ev_pop, ev_pop_cy, ev_pop_keep, ev_clash, ev_empty;
  rs_entry_t new_entry, top_entry;

  assign new_entry.cy = push_cy_i;
  assign new_entry.pc = next_ret_addr(push_pc_i);

  rs_decode u_dec (
    .push_i(push_i), .pop_cy_i(pop_cy_i), .pop_keep_i(pop_keep_i),
    .do_push_o(ev_push), .do_pop_o(ev_pop), .pop_cy_ok_o(ev_pop_cy),
    .pop_keep_ok_o(ev_pop_keep), .clash_o(ev_clash)
  );

  rs_storage #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .do_push_i(ev_push), .do_pop_i(ev_pop),
    .new_i(new_entry), .top_o(top_entry)
  );

  rs_depth #(.DEPTH(DEPTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .do_push_i(ev_push), .do_pop_i(ev_pop),
    .depth_o(depth_o), .empty_o(ev_empty)
  );

  rs_return u_ret (
    .clk(clk), .rst_n(rst_n), .pop_cy_i(ev_pop_cy), .pop_keep_i(ev_pop_keep),
    .empty_i(ev_empty), .clash_i(ev_clash), .top_i(top_entry),
    .imm_tbr_i(imm_tbr_i), .imm_acc_i(imm_acc_i),
    .ret_valid_o(ret_valid_o), .ret_pc_o(ret_pc_o), .ret_cy_o(ret_cy_o),
    .cy_load_o(cy_load_o), .ld_imm_o(ld_imm_o), .tbr_o(tbr_o), .acc_o(acc_o),
    .err_o(err_o)
  );
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH+1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic          pop_cy_i,
  input logic          pop_keep_i,
  input logic          ret_valid_o,
  input logic [10:0]   ret_pc_o,
  input logic          ret_cy_o,
  input logic          cy_load_o,
  input logic          ld_imm_o,
  input logic [CW-1:0] depth_o,
  input logic          err_o
);
  logic solo_push, solo_pop, clash;
  assign clash     = (32'(push_i) + 32'(pop_cy_i) + 32'(pop_keep_i)) > 32'd1;
  assign solo_push = push_i & ~pop_cy_i & ~pop_keep_i;
  assign solo_pop  = ~push_i & (pop_cy_i ^ pop_keep_i);

  AST_DEPTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CW'(DEPTH)); // R9
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    solo_push && depth_o < CW'(DEPTH) |=> depth_o == CW'($past(depth_o) + 1'b1)); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    solo_push && depth_o == CW'(DEPTH) |=> depth_o == CW'(DEPTH)); // R4
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clash |=> err_o && !ret_valid_o && $stable(depth_o)); // R8
  AST_POP_CY: assert property (@(posedge clk) disable iff (!rst_n)
    solo_pop && pop_cy_i |=> ret_valid_o && cy_load_o && !ld_imm_o); // R5
  AST_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    solo_pop && pop_keep_i |=> ret_valid_o && !cy_load_o && ld_imm_o); // R6
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    solo_pop && depth_o == '0 |=> ret_pc_o == '0 && !ret_cy_o && depth_o == '0); // R7
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_cy_i && !pop_keep_i |=> !ret_valid_o); // R5
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_cy_i(pop_cy_i),
  .pop_keep_i(pop_keep_i), .ret_valid_o(ret_valid_o), .ret_pc_o(ret_pc_o),
  .ret_cy_o(ret_cy_o), .cy_load_o(cy_load_o), .ld_imm_o(ld_imm_o),
  .depth_o(depth_o), .err_o(err_o)
);

// File: tb/tb_ret_stack.sv
module tb_ret_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push_i = 0, push_cy_i = 0, pop_cy_i = 0, pop_keep_i = 0;
  logic [10:0] push_pc_i = '0;
  logic [3:0]  imm_tbr_i = '0, imm_acc_i = '0;
  logic        ret_valid_o, ret_cy_o, cy_load_o, ld_imm_o, err_o;
  logic [10:0] ret_pc_o;
  logic [3:0]  tbr_o, acc_o;
  logic [2:0]  depth_o;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ret_stack dut (.*);

  // vector: {op[1:0] (0 idle,1 push,2 carry pop,3 value pop), cy, pc[10:0], exp_cy, exp_pc[10:0], exp_depth[2:0]}
  localparam logic [28:0] VEC [6] = '{
    {2'd1, 1'b1, 11'h010, 1'b0, 11'h000, 3'd1},
    {2'd1, 1'b0, 11'h7FF, 1'b0, 11'h000, 3'd2},
    {2'd1, 1'b1, 11'h123, 1'b0, 11'h000, 3'd3},
    {2'd2, 1'b0, 11'h000, 1'b1, 11'h124, 3'd2},
    {2'd2, 1'b0, 11'h000, 1'b0, 11'h000, 3'd1},
    {2'd2, 1'b0, 11'h000, 1'b1, 11'h011, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge; outputs are sampled at the next falling edge
  task automatic op(input logic p, input logic pc_c, input logic pk,
                    input logic [10:0] pc, input logic cy);
    @(negedge clk);
    push_i = p; pop_cy_i = pc_c; pop_keep_i = pk; push_pc_i = pc; push_cy_i = cy;
    @(negedge clk);
    push_i = 0; pop_cy_i = 0; pop_keep_i = 0;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 depth", 32'(depth_o), 0);
    chk("R1 flags", {ret_valid_o, cy_load_o, ld_imm_o, err_o, ret_cy_o}, 0);
    chk("R1 data", {ret_pc_o, tbr_o, acc_o}, 0);

    // R2 R3 R5 table walk
    foreach (VEC[i]) begin
      logic [28:0] v;
      v = VEC[i];
      op(v[28:27] == 2'd1, v[28:27] == 2'd2, v[28:27] == 2'd3, v[25:15], v[26]);
      chk("R2 depth", 32'(depth_o), 32'(v[2:0]));
      if (v[28:27] != 2'd1) begin
        chk("R3 ret_pc", 32'(ret_pc_o), 32'(v[13:3]));
        chk("R5 ret_cy", 32'(ret_cy_o), 32'(v[14]));
        chk("R5 valid/cyload", {ret_valid_o, cy_load_o}, 2'b11);
      end
    end

    // R4 overflow: five pushes, oldest 0x101 is lost
    for (int k = 0; k < 5; k++) op(1, 0, 0, 11'h100 + 11'(k), k[0]);
    chk("R4 depth full", 32'(depth_o), 4);
    for (int k = 4; k >= 1; k--) begin
      op(0, 1, 0, '0, 0);
      chk("R4 pop pc", 32'(ret_pc_o), 32'(11'h101 + 11'(k)));
      chk("R4 pop cy", 32'(ret_cy_o), 32'(k[0]));
    end
    chk("R9 depth zero", 32'(depth_o), 0);

    // R7 empty pop
    op(0, 1, 0, '0, 0);
    chk("R7 empty pc/cy", {ret_valid_o, ret_pc_o, ret_cy_o}, {1'b1, 11'h000, 1'b0});
    chk("R7 depth", 32'(depth_o), 0);

    // R6 value pop
    imm_tbr_i = 4'hA; imm_acc_i = 4'h5;
    op(1, 0, 0, 11'h200, 1);
    op(0, 0, 1, '0, 0);
    chk("R6 pc", 32'(ret_pc_o), 32'h201);
    chk("R6 strobes", {ret_valid_o, cy_load_o, ld_imm_o}, 3'b101);
    chk("R6 tbr/acc", {tbr_o, acc_o}, 8'hA5);

    // R8 clash leaves stack untouched
    op(1, 0, 0, 11'h300, 0);
    op(1, 1, 0, 11'h050, 1);
    chk("R8 err", {err_o, ret_valid_o}, 2'b10);
    chk("R8 depth", 32'(depth_o), 1);
    op(0, 1, 0, '0, 0);
    chk("R8 entry kept", {ret_pc_o, ret_cy_o, err_o}, {11'h301, 1'b0, 1'b0});
    chk("R9 depth back", 32'(depth_o), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule